// File: doc/BRIEF.md
# Edge-to-Edge Delay Meter

This block measures how long a response input takes to follow a reference input. Both inputs are already synchronous to the system clock and are examined once per clock, so every clock is one sample. A selectable edge on the reference input opens a measurement. The next selectable edge on the response input closes it and reports the number of samples in between. The result appears on a delay bus together with a single-cycle valid strobe.

Each measurement pairs one reference edge with exactly one later response edge. Edges that cannot be paired are counted instead of being silently dropped. A reference edge that arrives while a response is still awaited counts as a missed reference, and the measurement keeps its original start. A response edge that arrives with nothing pending counts as a missed response. Each of these two saturating counters has a one-cycle strobe that fires whenever the counter actually advances.

The result output is a valid-only stream with no ready input. The block cannot be stalled, so the consumer must take the delay bus in every cycle in which the valid strobe is high. The bus keeps its last value between strobes. The polarity selects and the counters are plain control and status pins.

Top module: `edge_delay_meter`

## Requirements
- R1: Each input has its own 2-bit polarity select. 0 selects rising (previous sample 0, current sample 1), 1 selects falling (previous 1, current 0), 2 selects both (previous differs from current), and 3 behaves as rising.
- R2: A response edge that closes a measurement drives `delay` with the number of samples from the start sample to that sample, and raises `delay_valid` for exactly one cycle, one clock after that sample.
- R3: With no measurement pending, a reference edge and a response edge in the same sample give a delay of 0, and no measurement is left pending.
- R4: A reference edge while a response is awaited leaves the start sample unchanged and advances `miss_ref_cnt`, with a one-cycle `miss_ref_pulse`.
- R5: With no measurement pending, a response edge advances `miss_rsp_cnt`, with a one-cycle `miss_rsp_pulse`. This happens only once at least one response edge has closed a measurement since reset.
- R6: A response edge and a reference edge in the same sample while a response is awaited first close the pending measurement. The same sample then starts a new measurement, whose delay is counted from that sample.
- R7: The delay saturates at 2^DLY_W-1 and each miss counter saturates at 2^MISS_W-1. A saturated counter gives no strobe.
- R8: Synchronous reset clears both counters, the strobes, the delay bus, any pending measurement and the response-seen condition. It also sets both stored previous samples to 0, so an input that is high on the first sample after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference input |
| rsp_in | input | 1 | Response input |
| ref_pol | input | 2 | Reference edge select (0 rise, 1 fall, 2 both, 3 rise) |
| rsp_pol | input | 2 | Response edge select (same encoding) |
| delay | output | DLY_W | Last measured delay in samples |
| delay_valid | output | 1 | One-cycle strobe for a new delay |
| miss_ref_cnt | output | MISS_W | Saturating count of missed reference edges |
| miss_ref_pulse | output | 1 | Strobe when miss_ref_cnt advances |
| miss_rsp_cnt | output | MISS_W | Saturating count of missed response edges |
| miss_rsp_pulse | output | 1 | Strobe when miss_rsp_cnt advances |

## Verification
A plain reference-then-response pair confirms the basic sample count. Pairs that coincide in one sample, both while idle and while pending, separate a zero delay from a close-and-restart. A second reference edge inside a window shows whether the start is kept or overwritten. Falling and both-edge selections, long waits, and runs of extra edges show that edge detection, delay saturation and counter saturation act independently. A lone response edge given before and after the first completed measurement, and a reset that arrives mid-measurement, confirm the conditions under which a missed response is counted.

// File: rtl/edm_pkg.sv
package edm_pkg;

  typedef enum logic [1:0] {
    POL_RISE     = 2'd0,
    POL_FALL     = 2'd1,
    POL_BOTH     = 2'd2,
    POL_RISE_ALT = 2'd3
  } pol_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } pair_st_e;

  localparam int NUM_CH = 2;
  localparam int CH_REF = 0;
  localparam int CH_RSP = 1;

  function automatic logic edge_match(input logic prev, input logic cur,
                                      input logic [1:0] pol);
    logic hit;
    case (pol)
      POL_FALL: hit = prev & ~cur;
      POL_BOTH: hit = prev ^ cur;
      default:  hit = ~prev & cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/edm_edge_det.sv
module edm_edge_det (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig,
  input  logic [1:0] pol,
  output logic       hit
);
  import edm_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign hit = edge_match(prev_q, sig, pol);
endmodule

// File: rtl/edm_sat_ctr.sv
module edm_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         pulse
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         pulse_q;
  logic         step;

  assign step = inc && (cnt_q != MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= step;
      if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt   = cnt_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/edm_pair_fsm.sv
module edm_pair_fsm #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_hit,
  input  logic             rsp_hit,
  output logic [DLY_W-1:0] delay,
  output logic             delay_valid,
  output logic             miss_ref_inc,
  output logic             miss_rsp_inc
);
  import edm_pkg::*;

  localparam logic [DLY_W-1:0] DMAX = {DLY_W{1'b1}};

  pair_st_e         st_q, st_d;
  logic [DLY_W-1:0] el_q, el_d, el_next;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             vld_q, vld_d;
  logic             seen_q, seen_d;

  assign el_next = (el_q == DMAX) ? DMAX : el_q + 1'b1;

  always_comb begin
    st_d         = st_q;
    el_d         = el_q;
    dly_d        = dly_q;
    vld_d        = 1'b0;
    seen_d       = seen_q;
    miss_ref_inc = 1'b0;
    miss_rsp_inc = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_hit) begin
          if (rsp_hit) begin
            vld_d  = 1'b1;
            dly_d  = '0;
            seen_d = 1'b1;
          end else begin
            st_d = ST_PEND;
            el_d = '0;
          end
        end else if (rsp_hit && seen_q) begin
          miss_rsp_inc = 1'b1;
        end
      end
      default: begin
        if (rsp_hit) begin
          vld_d  = 1'b1;
          dly_d  = el_next;
          seen_d = 1'b1;
          if (ref_hit) el_d = '0;
          else         st_d = ST_IDLE;
        end else begin
          el_d         = el_next;
          miss_ref_inc = ref_hit;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      el_q   <= '0;
      dly_q  <= '0;
      vld_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      el_q   <= el_d;
      dly_q  <= dly_d;
      vld_q  <= vld_d;
      seen_q <= seen_d;
    end
  end

  assign delay       = dly_q;
  assign delay_valid = vld_q;
endmodule

// File: rtl/edge_delay_meter.sv
module edge_delay_meter #(
  parameter int DLY_W  = 24,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              rsp_in,
  input  logic [1:0]        ref_pol,
  input  logic [1:0]        rsp_pol,
  output logic [DLY_W-1:0]  delay,
  output logic              delay_valid,
  output logic [MISS_W-1:0] miss_ref_cnt,
  output logic              miss_ref_pulse,
  output logic [MISS_W-1:0] miss_rsp_cnt,
  output logic              miss_rsp_pulse
);
  import edm_pkg::*;

  logic [NUM_CH-1:0] sig_v;
  logic [NUM_CH-1:0] hit_v;
  logic [1:0]        pol_v [NUM_CH];
  logic              ref_hit, rsp_hit;
  logic              mref_inc, mrsp_inc;

  assign sig_v[CH_REF] = ref_in;
  assign sig_v[CH_RSP] = rsp_in;
  assign pol_v[CH_REF] = ref_pol;
  assign pol_v[CH_RSP] = rsp_pol;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    edm_edge_det u_det (
      .clk (clk),
      .rst (rst),
      .sig (sig_v[g]),
      .pol (pol_v[g]),
      .hit (hit_v[g])
    );
  end

  assign ref_hit = hit_v[CH_REF];
  assign rsp_hit = hit_v[CH_RSP];

  edm_pair_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ref_hit      (ref_hit),
    .rsp_hit      (rsp_hit),
    .delay        (delay),
    .delay_valid  (delay_valid),
    .miss_ref_inc (mref_inc),
    .miss_rsp_inc (mrsp_inc)
  );

  edm_sat_ctr #(.W(MISS_W)) u_mref (
    .clk   (clk),
    .rst   (rst),
    .inc   (mref_inc),
    .cnt   (miss_ref_cnt),
    .pulse (miss_ref_pulse)
  );

  edm_sat_ctr #(.W(MISS_W)) u_mrsp (
    .clk   (clk),
    .rst   (rst),
    .inc   (mrsp_inc),
    .cnt   (miss_rsp_cnt),
    .pulse (miss_rsp_pulse)
  );
endmodule

// File: rtl/edm_checker.sv
module edm_checker #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_hit,
  input logic              rsp_hit,
  input logic              delay_valid,
  input logic              miss_ref_pulse,
  input logic [MISS_W-1:0] miss_ref_cnt,
  input logic              miss_rsp_pulse,
  input logic [MISS_W-1:0] miss_rsp_cnt
);
  a_r2_valid_follows_rsp_edge: assert property (@(posedge clk) disable iff (rst)
    delay_valid |-> $past(rsp_hit));

  a_r4_ref_miss_needs_ref_edge: assert property (@(posedge clk) disable iff (rst)
    miss_ref_pulse |-> $past(ref_hit));

  a_r4_ref_cnt_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    miss_ref_pulse |-> miss_ref_cnt == MISS_W'($past(miss_ref_cnt) + 1'b1));

  a_r7_ref_cnt_holds: assert property (@(posedge clk) disable iff (rst)
    !miss_ref_pulse |-> miss_ref_cnt == $past(miss_ref_cnt));

  a_r5_rsp_miss_not_with_result: assert property (@(posedge clk) disable iff (rst)
    miss_rsp_pulse |-> ($past(rsp_hit) && !delay_valid));

  a_r5_rsp_cnt_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    miss_rsp_pulse |-> miss_rsp_cnt == MISS_W'($past(miss_rsp_cnt) + 1'b1));

  a_r7_rsp_cnt_holds: assert property (@(posedge clk) disable iff (rst)
    !miss_rsp_pulse |-> miss_rsp_cnt == $past(miss_rsp_cnt));
endmodule

bind edge_delay_meter edm_checker #(.MISS_W(MISS_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ref_hit        (ref_hit),
  .rsp_hit        (rsp_hit),
  .delay_valid    (delay_valid),
  .miss_ref_pulse (miss_ref_pulse),
  .miss_ref_cnt   (miss_ref_cnt),
  .miss_rsp_pulse (miss_rsp_pulse),
  .miss_rsp_cnt   (miss_rsp_cnt)
);

// File: tb/sim_edge_delay_meter.sv
module sim_edge_delay_meter;
  localparam int DW = 8;
  localparam int MW = 4;
  localparam int DMAX = (1 << DW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          ref_i = 1'b0, rsp_i = 1'b0;
  logic [1:0]    ref_pol = 2'd0, rsp_pol = 2'd0;
  logic [DW-1:0] delay;
  logic          delay_valid;
  logic [MW-1:0] mref_cnt, mrsp_cnt;
  logic          mref_pulse, mrsp_pulse;

  edge_delay_meter #(.DLY_W(DW), .MISS_W(MW)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_i), .rsp_in(rsp_i),
    .ref_pol(ref_pol), .rsp_pol(rsp_pol),
    .delay(delay), .delay_valid(delay_valid),
    .miss_ref_cnt(mref_cnt), .miss_ref_pulse(mref_pulse),
    .miss_rsp_cnt(mrsp_cnt), .miss_rsp_pulse(mrsp_pulse)
  );

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int n_ref_pulse = 0, n_rsp_pulse = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic s);
    ref_i = r;
    rsp_i = s;
    @(negedge clk);
  endtask

  task automatic expect_delay(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: scoreboard for delays, pulse tallies for the counters
  always @(negedge clk) begin
    if (rst) begin
      n_ref_pulse = 0;
      n_rsp_pulse = 0;
    end else begin
      if (mref_pulse) n_ref_pulse++;
      if (mrsp_pulse) n_rsp_pulse++;
      if (delay_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected delay strobe", int'(delay), -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(delay) == e, t, "delay", int'(delay), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(delay_valid == 1'b0 && delay == '0, "R8", "valid/delay in reset", int'(delay_valid), 0);
    chk(mref_cnt == '0 && mrsp_cnt == '0, "R8", "counters in reset", int'(mref_cnt) + int'(mrsp_cnt), 0);
    rst = 1'b0;
    cyc(0, 0);

    // R5: lone response before any completed measurement is not counted
    cyc(0, 1); cyc(0, 0);
    chk(mrsp_cnt == 0, "R5", "rsp miss before first result", int'(mrsp_cnt), 0);

    // R2: plain pair, 5 samples apart
    cyc(1, 0);
    repeat (4) cyc(1, 0);
    expect_delay(5, "R2");
    cyc(1, 1);
    cyc(0, 0);

    // R5: lone response after a completed measurement
    cyc(0, 1); cyc(0, 0);
    chk(mrsp_cnt == 1, "R5", "rsp miss after first result", int'(mrsp_cnt), 1);

    // R3: coincident edges while idle
    expect_delay(0, "R3");
    cyc(1, 1);
    cyc(0, 0);
    chk(mrsp_cnt == 1, "R3", "no rsp miss on coincident pair", int'(mrsp_cnt), 1);

    // R4: second reference edge keeps the first start
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
    expect_delay(4, "R4");
    cyc(0, 1);
    chk(mref_cnt == 1, "R4", "ref miss count", int'(mref_cnt), 1);

    // R6: close and restart in the same sample
    cyc(0, 0);
    cyc(1, 0); cyc(0, 0);
    expect_delay(2, "R6");
    cyc(1, 1);
    cyc(0, 0); cyc(0, 0);
    expect_delay(3, "R6");
    cyc(0, 1);
    chk(mref_cnt == 1, "R6", "restart is not a ref miss", int'(mref_cnt), 1);
    cyc(0, 0);

    // R1: falling reference, both-edge response
    ref_pol = 2'd1; rsp_pol = 2'd2;
    cyc(1, 0);
    cyc(0, 0);
    expect_delay(1, "R1");
    cyc(0, 1);
    cyc(0, 0);
    chk(mrsp_cnt == 2, "R1", "falling rsp edge seen in both mode", int'(mrsp_cnt), 2);
    cyc(1, 0);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    expect_delay(3, "R1");
    cyc(0, 1);
    ref_pol = 2'd0; rsp_pol = 2'd0;
    cyc(0, 0);
    chk(mrsp_cnt == 2, "R1", "falling rsp ignored in rising mode", int'(mrsp_cnt), 2);
    // R1: code 3 behaves as rising
    ref_pol = 2'd3;
    cyc(1, 0);
    expect_delay(1, "R1");
    cyc(1, 1);
    cyc(0, 0);
    ref_pol = 2'd0;

    // R7: delay saturation
    cyc(1, 0);
    repeat (299) cyc(1, 0);
    expect_delay(DMAX, "R7");
    cyc(1, 1);
    cyc(0, 0);

    // R7: missed-reference saturation
    cyc(1, 0);
    for (int i = 0; i < 20; i++) begin
      cyc(0, 0); cyc(1, 0);
    end
    expect_delay(41, "R4");
    cyc(1, 1);
    cyc(0, 0);
    chk(mref_cnt == MMAX, "R7", "ref miss saturated", int'(mref_cnt), MMAX);
    chk(n_ref_pulse == MMAX, "R7", "ref miss strobes", n_ref_pulse, MMAX);

    // R7: missed-response saturation
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1); cyc(0, 0);
    end
    chk(mrsp_cnt == MMAX, "R7", "rsp miss saturated", int'(mrsp_cnt), MMAX);
    chk(n_rsp_pulse == MMAX, "R7", "rsp miss strobes", n_rsp_pulse, MMAX);

    // R8: reset mid-measurement, high input on first sample is an edge
    cyc(1, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(mref_cnt == 0 && mrsp_cnt == 0, "R8", "counters cleared", int'(mref_cnt) + int'(mrsp_cnt), 0);
    chk(delay_valid == 1'b0 && delay == '0, "R8", "result cleared", int'(delay), 0);
    rst = 1'b0;
    @(negedge clk);
    expect_delay(1, "R8");
    cyc(1, 1);
    cyc(0, 0);
    repeat (4) cyc(0, 0);

    chk(exp_q.size() == 0, "R2", "pending expected results", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule